// File: doc/BRIEF.md
# Fused-Operation Integer Execution Unit

This unit executes the single internal operations that a front end issues after it has merged two adjacent simple integer instructions into one. Each merged idiom becomes a single-cycle datapath operation on two 64-bit operands. Those idioms include a shift followed by an add, a word zero-extension followed by a small left shift, extraction of one byte, a low-bit add, a masked OR, a 32-bit add followed by a narrowing or extension, and a logic operation followed by a narrowing. A 5-bit select code picks the operation. Any code outside the defined set returns zero and raises an illegal flag.

The arithmetic is fully combinational and is split across three leaf units: the shift-and-add group, the narrowing group and the logic group. Their results are merged at the top. An optional output register, enabled by default, captures the result and the illegal flag on each clock edge where `in_valid` is high, and it reports a valid bit one cycle later.

Top module: `fuse_alu`

## Requirements
- R1: Codes 0 to 3 return (src1 << k) + src2, with k = 1, 2, 3, 4 in that order, computed modulo 2^64.
- R2: Codes 4 to 7 return (src1 >> k) + src2, with k = 29, 30, 31, 32 in that order. The right shift is logical.
- R3: Codes 8 to 10 zero-extend src1[31:0] to 64 bits and then shift it left by 1, 2 or 3 respectively.
- R4: Code 11 returns src1[15:8] in bits 7:0, with every higher bit zero.
- R5: Code 12 returns src1[0] + src2 as a 64-bit add. Code 13 returns the low 32 bits of src1[0] + src2, sign-extended from bit 31.
- R6: Code 14 returns {src1[63:8], 8'h00} | src2.
- R7: Codes 15 to 18 first form the 32-bit sum s = src1[31:0] + src2[31:0]. They then return, in order: s[7:0] zero-extended, s[0] zero-extended, s[15:0] zero-extended, and s[15:0] sign-extended.
- R8: Codes 19, 20 and 21 apply AND, OR and XOR respectively to the operands and return bit 0 of the result, zero-extended. Codes 22, 23 and 24 apply the same three operations in the same order and return bits 15:0 of the result, zero-extended.
- R9: Codes 25 to 31 return zero and drive `illegal` high. Every defined code drives `illegal` low.
- R10: With the output register enabled, a clock edge where `in_valid` is high loads `result` and `illegal` and sets `out_valid` high for the next cycle. An edge where `in_valid` is low clears `out_valid` and leaves `result` and `illegal` unchanged.
- R11: A synchronous `rst` clears `out_valid`, `result` and `illegal` to zero, even when `in_valid` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select code are valid this cycle |
| op_sel | input | 5 | Operation select code |
| src1 | input | 64 | First operand |
| src2 | input | 64 | Second operand |
| result | output | 64 | Operation result (registered by default) |
| illegal | output | 1 | Select code was undefined |
| out_valid | output | 1 | Result was captured at the previous edge |

## Verification
Two things can fall in the same cycle. The first is the capture of a new operation. The second is the retirement of the previous one, whether that one was legal or illegal. The bench drives every code back to back with `in_valid` held high, so an illegal code is immediately followed by a legal one, and the reverse. In each cycle it checks that `illegal`, `result` and `out_valid` reflect only the operation captured at the preceding edge. It also places reset in a cycle where `in_valid` is high, and checks that the clear wins over the capture.

// File: rtl/fuse_alu_pkg.sv
`timescale 1ns/1ps
package fuse_alu_pkg;

    localparam int XLEN  = 64;
    localparam int WORD  = 32;
    localparam int HALF  = 16;
    localparam int BYTE  = 8;
    localparam int OPW   = 5;

    localparam int NSHL       = 4;   // shift-left-add variants
    localparam int NSHR       = 4;   // shift-right-add variants
    localparam int NZW        = 3;   // zero-extended word shift variants
    localparam int SHR_BASE_K = 29;  // smallest right-shift amount
    localparam int NLOGIC     = 3;   // and, or, xor

    typedef enum logic [OPW-1:0] {
        OP_SHL1_ADD  = 5'd0,
        OP_SHL2_ADD  = 5'd1,
        OP_SHL3_ADD  = 5'd2,
        OP_SHL4_ADD  = 5'd3,
        OP_SHR29_ADD = 5'd4,
        OP_SHR30_ADD = 5'd5,
        OP_SHR31_ADD = 5'd6,
        OP_SHR32_ADD = 5'd7,
        OP_ZW_SHL1   = 5'd8,
        OP_ZW_SHL2   = 5'd9,
        OP_ZW_SHL3   = 5'd10,
        OP_BYTE1     = 5'd11,
        OP_ODD_ADD   = 5'd12,
        OP_ODD_ADDW  = 5'd13,
        OP_MASK_OR   = 5'd14,
        OP_WADD_BYTE = 5'd15,
        OP_WADD_BIT  = 5'd16,
        OP_WADD_ZH   = 5'd17,
        OP_WADD_SH   = 5'd18,
        OP_AND_LSB   = 5'd19,
        OP_OR_LSB    = 5'd20,
        OP_XOR_LSB   = 5'd21,
        OP_AND_ZH    = 5'd22,
        OP_OR_ZH     = 5'd23,
        OP_XOR_ZH    = 5'd24
    } fop_e;

    typedef struct packed {
        logic            hit;
        logic [XLEN-1:0] data;
    } unit_res_t;

    function automatic logic [OPW-1:0] op_off(input fop_e op, input fop_e base);
        logic [OPW-1:0] o;
        logic [OPW-1:0] b;
        o = op;
        b = base;
        return o - b;
    endfunction

    function automatic logic [XLEN-1:0] zext_w(input logic [WORD-1:0] v);
        return {{(XLEN-WORD){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_w(input logic [WORD-1:0] v);
        return {{(XLEN-WORD){v[WORD-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_h(input logic [HALF-1:0] v);
        return {{(XLEN-HALF){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_h(input logic [HALF-1:0] v);
        return {{(XLEN-HALF){v[HALF-1]}}, v};
    endfunction

endpackage

// File: rtl/fuse_shift_add.sv
`timescale 1ns/1ps
module fuse_shift_add
    import fuse_alu_pkg::*;
(
    input  fop_e            op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output unit_res_t       res
);

    logic [XLEN-1:0] shl_v [NSHL];
    logic [XLEN-1:0] shr_v [NSHR];
    logic [XLEN-1:0] zw_v  [NZW];

    for (genvar i = 0; i < NSHL; i++) begin : g_shl
        assign shl_v[i] = (a << (i + 1)) + b;
    end

    for (genvar i = 0; i < NSHR; i++) begin : g_shr
        assign shr_v[i] = (a >> (SHR_BASE_K + i)) + b;
    end

    for (genvar i = 0; i < NZW; i++) begin : g_zw
        assign zw_v[i] = zext_w(a[WORD-1:0]) << (i + 1);
    end

    logic [OPW-1:0] off;

    always_comb begin
        res = '0;
        off = '0;
        if (op >= OP_SHL1_ADD && op <= OP_SHL4_ADD) begin
            off      = op_off(op, OP_SHL1_ADD);
            res.hit  = 1'b1;
            res.data = shl_v[off[1:0]];
        end else if (op >= OP_SHR29_ADD && op <= OP_SHR32_ADD) begin
            off      = op_off(op, OP_SHR29_ADD);
            res.hit  = 1'b1;
            res.data = shr_v[off[1:0]];
        end else if (op >= OP_ZW_SHL1 && op <= OP_ZW_SHL3) begin
            off      = op_off(op, OP_ZW_SHL1);
            res.hit  = 1'b1;
            res.data = zw_v[off[1:0]];
        end
    end

endmodule

// File: rtl/fuse_narrow.sv
`timescale 1ns/1ps
module fuse_narrow
    import fuse_alu_pkg::*;
(
    input  fop_e            op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output unit_res_t       res
);

    logic [WORD-1:0] wsum;
    logic [XLEN-1:0] odd_sum;

    assign wsum    = a[WORD-1:0] + b[WORD-1:0];
    assign odd_sum = {{(XLEN-1){1'b0}}, a[0]} + b;

    always_comb begin
        res = '0;
        unique case (op)
            OP_BYTE1: begin
                res.hit  = 1'b1;
                res.data = {{(XLEN-BYTE){1'b0}}, a[2*BYTE-1:BYTE]};
            end
            OP_ODD_ADD: begin
                res.hit  = 1'b1;
                res.data = odd_sum;
            end
            OP_ODD_ADDW: begin
                res.hit  = 1'b1;
                res.data = sext_w(odd_sum[WORD-1:0]);
            end
            OP_MASK_OR: begin
                res.hit  = 1'b1;
                res.data = {a[XLEN-1:BYTE], {BYTE{1'b0}}} | b;
            end
            OP_WADD_BYTE: begin
                res.hit  = 1'b1;
                res.data = {{(XLEN-BYTE){1'b0}}, wsum[BYTE-1:0]};
            end
            OP_WADD_BIT: begin
                res.hit  = 1'b1;
                res.data = {{(XLEN-1){1'b0}}, wsum[0]};
            end
            OP_WADD_ZH: begin
                res.hit  = 1'b1;
                res.data = zext_h(wsum[HALF-1:0]);
            end
            OP_WADD_SH: begin
                res.hit  = 1'b1;
                res.data = sext_h(wsum[HALF-1:0]);
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fuse_logic.sv
`timescale 1ns/1ps
module fuse_logic
    import fuse_alu_pkg::*;
(
    input  fop_e            op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output unit_res_t       res
);

    logic [XLEN-1:0] lv [NLOGIC];

    assign lv[0] = a & b;
    assign lv[1] = a | b;
    assign lv[2] = a ^ b;

    logic [OPW-1:0] off;

    always_comb begin
        res = '0;
        off = '0;
        if (op >= OP_AND_LSB && op <= OP_XOR_LSB) begin
            off      = op_off(op, OP_AND_LSB);
            res.hit  = 1'b1;
            res.data = {{(XLEN-1){1'b0}}, lv[off[1:0]][0]};
        end else if (op >= OP_AND_ZH && op <= OP_XOR_ZH) begin
            off      = op_off(op, OP_AND_ZH);
            res.hit  = 1'b1;
            res.data = zext_h(lv[off[1:0]][HALF-1:0]);
        end
    end

endmodule

// File: rtl/fuse_alu.sv
`timescale 1ns/1ps
module fuse_alu
    import fuse_alu_pkg::*;
#(
    parameter bit USE_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OPW-1:0]  op_sel,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    output logic [XLEN-1:0] result,
    output logic            illegal,
    output logic            out_valid
);

    localparam int NUNIT = 3;

    fop_e      op;
    unit_res_t sa_res;
    unit_res_t nw_res;
    unit_res_t lg_res;

    assign op = fop_e'(op_sel);

    fuse_shift_add u_shift_add (.op(op), .a(src1), .b(src2), .res(sa_res));
    fuse_narrow    u_narrow    (.op(op), .a(src1), .b(src2), .res(nw_res));
    fuse_logic     u_logic     (.op(op), .a(src1), .b(src2), .res(lg_res));

    logic [NUNIT-1:0] hits;
    logic [XLEN-1:0]  comb_data;
    logic             comb_ill;

    assign hits      = {lg_res.hit, nw_res.hit, sa_res.hit};
    assign comb_data = sa_res.data | nw_res.data | lg_res.data;
    assign comb_ill  = ~|hits;

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        comb_ill |-> (comb_data == '0));

    // R9
    unit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));

    // R8
    lsb_width_chk: assert property (@(posedge clk) disable iff (rst)
        (op >= OP_AND_LSB && op <= OP_XOR_LSB) |-> (comb_data[XLEN-1:1] == '0));

    // R7
    wadd_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WADD_BIT) |-> (comb_data[XLEN-1:1] == '0));

    if (USE_REG) begin : g_reg
        logic [XLEN-1:0] res_q;
        logic            ill_q;
        logic            vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                ill_q <= 1'b0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= comb_data;
                    ill_q <= comb_ill;
                end
            end
        end

        assign result    = res_q;
        assign illegal   = ill_q;
        assign out_valid = vld_q;

        // R10
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_valid && result == $past(comb_data)));

        // R10
        idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        // R10
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(result) && $stable(illegal)));
    end else begin : g_comb
        assign result    = comb_data;
        assign illegal   = comb_ill;
        assign out_valid = in_valid;
    end

endmodule

// File: tb/tb_fuse_alu.sv
`timescale 1ns/1ps
module tb_fuse_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [63:0] src1 = '0;
    logic [63:0] src2 = '0;
    logic [63:0] result;
    logic        illegal;
    logic        out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fuse_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .src1(src1), .src2(src2), .result(result), .illegal(illegal),
        .out_valid(out_valid)
    );

    function automatic string req_of(input int c);
        if (c <= 3)  return "R1";
        if (c <= 7)  return "R2";
        if (c <= 10) return "R3";
        if (c == 11) return "R4";
        if (c <= 13) return "R5";
        if (c == 14) return "R6";
        if (c <= 18) return "R7";
        if (c <= 24) return "R8";
        return "R9";
    endfunction

    function automatic logic [63:0] model(input int c, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [31:0] s;
        logic [31:0] w;
        logic [63:0] l;
        s = a[31:0] + b[31:0];
        if (c <= 3) return (a << (c + 1)) + b;
        if (c <= 7) return (a >> (c + 25)) + b;
        if (c <= 10) return {32'h0, a[31:0]} << (c - 7);
        if (c == 11) return {56'h0, a[15:8]};
        if (c == 12) return {63'h0, a[0]} + b;
        if (c == 13) begin
            w = {31'h0, a[0]} + b[31:0];
            return {{32{w[31]}}, w};
        end
        if (c == 14) return {a[63:8], 8'h00} | b;
        if (c == 15) return {56'h0, s[7:0]};
        if (c == 16) return {63'h0, s[0]};
        if (c == 17) return {48'h0, s[15:0]};
        if (c == 18) return {{48{s[15]}}, s[15:0]};
        if (c <= 24) begin
            case ((c - 19) % 3)
                0:       l = a & b;
                1:       l = a | b;
                default: l = a ^ b;
            endcase
            if (c <= 21) return {63'h0, l[0]};
            return {48'h0, l[15:0]};
        end
        return 64'h0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // drive at a falling edge, check at the following falling edge
    task automatic run_op(input int c, input logic [63:0] a, input logic [63:0] b);
        op_sel   = c[4:0];
        src1     = a;
        src2     = b;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_of(c), $sformatf("result code %0d", c), result, model(c, a, b));
        chk("R9", $sformatf("illegal code %0d", c), {63'h0, illegal},
            {63'h0, (c > 24)});
        chk("R10", "out_valid after capture", {63'h0, out_valid}, 64'h1);
    endtask

    logic [63:0] fa [6];
    logic [63:0] fb [6];

    initial begin
        fa[0] = 64'hFFFF_FFFF_FFFF_FFFF; fb[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        fa[1] = 64'h0;                   fb[1] = 64'h0;
        fa[2] = 64'h8000_0000_7FFF_FFFF; fb[2] = 64'h0000_0000_0000_0001;
        fa[3] = 64'h0000_0000_FFFF_FFFF; fb[3] = 64'h0000_0000_0000_0001;
        fa[4] = 64'hFFFF_FFFF_FFFF_FF01; fb[4] = 64'h0000_0000_0000_00F0;
        fa[5] = 64'h1234_5678_9ABC_DEF1; fb[5] = 64'h0000_0000_0000_7FFF;

        repeat (2) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        chk("R11", "result in reset", result, 64'h0);
        chk("R11", "illegal in reset", {63'h0, illegal}, 64'h0);
        rst = 1'b0;

        // every code, back to back, including illegal codes next to legal ones
        for (int c = 0; c < 32; c++) begin
            for (int v = 0; v < 6; v++) run_op(c, fa[v], fb[v]);
            for (int v = 0; v < 10; v++) begin
                logic [63:0] ra;
                rng = next_rand(rng);
                ra  = rng;
                rng = next_rand(rng);
                run_op(c, ra, rng);
            end
        end

        // alternating illegal / legal without a gap (R9)
        for (int k = 0; k < 8; k++) begin
            run_op(25 + (k % 7), 64'hDEAD_BEEF_0000_0001, 64'h5);
            run_op(k, 64'hDEAD_BEEF_0000_0001, 64'h5);
        end

        // R10 idle hold: in_valid low, operands change, nothing moves
        begin
            logic [63:0] held_res;
            logic        held_ill;
            run_op(30, 64'h1, 64'h2);
            held_res = result;
            held_ill = illegal;
            for (int k = 0; k < 4; k++) begin
                in_valid = 1'b0;
                op_sel   = 5'(k);
                src1     = 64'hAAAA_5555_AAAA_5555 + 64'(k);
                src2     = 64'h1357_9BDF_2468_ACE0;
                @(posedge clk);
                @(negedge clk);
                chk("R10", "out_valid idle", {63'h0, out_valid}, 64'h0);
                chk("R10", "result held idle", result, held_res);
                chk("R10", "illegal held idle", {63'h0, illegal}, {63'h0, held_ill});
            end
        end

        // R11 reset wins over a capture in the same cycle
        run_op(30, 64'h7, 64'h7);
        rst      = 1'b1;
        in_valid = 1'b1;
        op_sel   = 5'd14;
        src1     = 64'hFFFF_FFFF_FFFF_FFFF;
        src2     = 64'h1;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "out_valid after reset with in_valid", {63'h0, out_valid}, 64'h0);
        chk("R11", "result after reset with in_valid", result, 64'h0);
        chk("R11", "illegal after reset with in_valid", {63'h0, illegal}, 64'h0);
        rst = 1'b0;
        run_op(14, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);

        in_valid = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule